// File: doc/BRIEF.md
# Dual-Edge Testable Data Flip-Flop

This block stores a data word on both clock edges. Two level-sensitive latches sit side by side and both take the same input. One is transparent while the clock is high and the other while the clock is low. A selector, steered by the clock, always drives the output from whichever latch is currently closed. Each stored word therefore appears at the output on the edge that closed its latch and stays there until the opposite edge. A stream that needs one word per edge can run on a clock at half the rate a single-edge register would need.

Every latch is built from controlled-swap gates: one gate chooses between fresh data and the held value, and a second gate drives the latch output. Each latch has its own pair of control inputs on that second gate. With the pair at (low, high) the gate passes its value through. With both high the latch output is forced to ones, which exposes stuck-at-0 faults. With both low it is forced to zeros, which exposes stuck-at-1 faults. Forcing one latch affects only the clock phase in which that latch drives the output. The block has no reset.

Top module: `dual_edge_dff`

## Requirements
- R1: With all four controls in normal mode (c1 low, c2 high on both latches), q equals the d value present at a rising edge from just after that edge until the next falling edge.
- R2: In normal mode, q equals the d value present at a falling edge from just after that edge until the next rising edge.
- R3: Changes on d between two clock edges never reach q in normal mode.
- R4: With all four controls high, q is all ones whatever d and clk do.
- R5: With all four controls low, q is all zeros whatever d and clk do.
- R6: With only the positive-enable latch forced high and the negative-enable latch normal, q is all ones while clk is low and equals the d value at the last rising edge while clk is high.
- R7: After the controls return to normal mode, the first following clock edge captures d correctly.
- R8: Each bit of d is stored independently of the other bits; the data width is the parameter WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Both of its edges store data. |
| d | input | WIDTH | Data input, shared by both latches. |
| pos_c1 | input | 1 | Test control 1 of the latch that is transparent while clk is high. |
| pos_c2 | input | 1 | Test control 2 of the latch that is transparent while clk is high. |
| neg_c1 | input | 1 | Test control 1 of the latch that is transparent while clk is low. |
| neg_c2 | input | 1 | Test control 2 of the latch that is transparent while clk is low. |
| q | output | WIDTH | Stored data word, or the forced test value. |

## Verification
A wrong held value in the negative-enable latch shows on q during the whole high phase after a rising edge. A wrong value in the positive-enable latch shows during the whole low phase after a falling edge. Either error is therefore visible half a clock period after the edge that stored it. A selector steered the wrong way makes q follow d while the clock is at a level, so a change of d in mid-phase reaches q within the same half period. A broken test gate shows as soon as its controls change, because the forced value does not depend on the clock.

// File: rtl/dual_edge_dff.sv
`timescale 1ns/1ps
module dual_edge_dff #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  input  logic             pos_c1,
  input  logic             pos_c2,
  input  logic             neg_c1,
  input  logic             neg_c2,
  output logic [WIDTH-1:0] q
);

  // controlled swap: the kept output passes a when ctl is 0 and b when ctl is 1;
  // the companion output is garbage and is not built
  function automatic logic [WIDTH-1:0] cswap(input logic [WIDTH-1:0] ctl,
                                             input logic [WIDTH-1:0] a,
                                             input logic [WIDTH-1:0] b);
    return (~ctl & a) | (ctl & b);
  endfunction

  localparam logic [WIDTH-1:0] ONES = '1;

  logic [WIDTH-1:0] clk_w;
  logic [WIDTH-1:0] hold_p, hold_n;
  logic [WIDTH-1:0] path_p, path_n;
  logic [WIDTH-1:0] out_p, out_n;

  assign clk_w = clk ? ONES : '0;

  always_latch begin
    if (clk) hold_p <= d;
  end

  always_latch begin
    if (!clk) hold_n <= d;
  end

  assign path_p = cswap(clk_w, hold_p, d);
  assign path_n = cswap(clk_w, d, hold_n);

  assign out_p = cswap(path_p, pos_c1 ? ONES : '0, pos_c2 ? ONES : '0);
  assign out_n = cswap(path_n, neg_c1 ? ONES : '0, neg_c2 ? ONES : '0);

  assign q = cswap(clk_w, out_p, out_n);

endmodule

// File: rtl/dual_edge_dff_chk.sv
`timescale 1ns/1ps
module dual_edge_dff_chk #(
  parameter int WIDTH = 1
) (
  input logic             clk,
  input logic [WIDTH-1:0] d,
  input logic             pos_c1,
  input logic             pos_c2,
  input logic             neg_c1,
  input logic             neg_c2,
  input logic [WIDTH-1:0] q
);
  logic             rise_seen = 1'b0;
  logic             fall_seen = 1'b0;
  logic [WIDTH-1:0] d_rise, d_fall;
  logic             norm_rise, norm_fall;
  logic             norm, all_hi, all_lo, pos_only_hi;

  assign norm        = !pos_c1 && pos_c2 && !neg_c1 && neg_c2;
  assign all_hi      = pos_c1 && pos_c2 && neg_c1 && neg_c2;
  assign all_lo      = !pos_c1 && !pos_c2 && !neg_c1 && !neg_c2;
  assign pos_only_hi = pos_c1 && pos_c2 && !neg_c1 && neg_c2;

  always_ff @(posedge clk) begin
    rise_seen <= 1'b1;
    d_rise    <= d;
    norm_rise <= norm;
  end

  always_ff @(negedge clk) begin
    fall_seen <= 1'b1;
    d_fall    <= d;
    norm_fall <= norm;
  end

  AST_RISE_HOLD: assert property (@(negedge clk) disable iff (!rise_seen)
    (norm_rise && norm) |-> (q == d_rise)); // R1
  AST_FALL_HOLD: assert property (@(posedge clk) disable iff (!fall_seen)
    (norm_fall && norm) |-> (q == d_fall)); // R2
  AST_FORCE_ONES: assert property (@(posedge clk) disable iff (!rise_seen)
    all_hi |-> (q == '1)); // R4
  AST_FORCE_ZEROS: assert property (@(negedge clk) disable iff (!fall_seen)
    all_lo |-> (q == '0)); // R5
  AST_POS_PHASE_ONLY: assert property (@(posedge clk) disable iff (!fall_seen)
    pos_only_hi |-> (q == '1)); // R6
endmodule

bind dual_edge_dff dual_edge_dff_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .d(d), .pos_c1(pos_c1), .pos_c2(pos_c2),
  .neg_c1(neg_c1), .neg_c2(neg_c2), .q(q)
);

// File: tb/tb_dual_edge_dff.sv
`timescale 1ns/1ps
module tb_dual_edge_dff;
  localparam int W = 4;
  localparam int NV = 12;
  // each entry: [7:4] d at rising edge, [3:0] d at falling edge (distinct bits, R8)
  localparam logic [7:0] VEC [0:NV-1] = '{
    8'h5A, 8'hA5, 8'h00, 8'hFF, 8'h0F, 8'hF0,
    8'h12, 8'h48, 8'h81, 8'h3C, 8'hC3, 8'h77
  };

  logic         clk = 1'b0;
  logic [W-1:0] d = '0;
  logic         pos_c1 = 1'b0, pos_c2 = 1'b1, neg_c1 = 1'b0, neg_c2 = 1'b1;
  logic [W-1:0] q;
  logic [W-1:0] ref_r = '0, ref_f = '0;
  int checks = 0;
  int errors = 0;

  dual_edge_dff #(.WIDTH(W)) dut (
    .clk(clk), .d(d), .pos_c1(pos_c1), .pos_c2(pos_c2),
    .neg_c1(neg_c1), .neg_c2(neg_c2), .q(q)
  );

  always #5 clk = ~clk;

  // two-register reference: one register per edge
  always @(posedge clk) ref_r <= d;
  always @(negedge clk) ref_f <= d;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: q=%h expected=done", q);
    summary();
    $finish;
  end

  initial begin
    logic [W-1:0] hi, lo;
    for (int i = 0; i < NV; i++) begin
      hi = VEC[i][7:4];
      lo = VEC[i][3:0];
      d = hi;
      @(posedge clk); #1;
      chk("R1 rise capture", q, hi);
      chk("R1 reference model", q, ref_r);
      d = ~hi;
      #2;
      chk("R3 mid-high d change", q, hi);
      d = lo;
      @(negedge clk); #1;
      chk("R2 fall capture", q, lo);
      chk("R2 reference model", q, ref_f);
      d = ~lo;
      #2;
      chk("R3 mid-low d change", q, lo);
    end

    pos_c1 = 1'b1; pos_c2 = 1'b1; neg_c1 = 1'b1; neg_c2 = 1'b1;
    d = 4'h0;
    #1; chk("R4 ones, low phase", q, 4'hF);
    @(posedge clk); #1; chk("R4 ones, high phase", q, 4'hF);
    d = 4'h6; #2; chk("R4 ones, d moves", q, 4'hF);
    @(negedge clk); #1; chk("R4 ones, after fall", q, 4'hF);

    pos_c1 = 1'b0; pos_c2 = 1'b0; neg_c1 = 1'b0; neg_c2 = 1'b0;
    d = 4'hF;
    #1; chk("R5 zeros, low phase", q, 4'h0);
    @(posedge clk); #1; chk("R5 zeros, high phase", q, 4'h0);
    @(negedge clk); #1; chk("R5 zeros, after fall", q, 4'h0);

    pos_c1 = 1'b1; pos_c2 = 1'b1; neg_c1 = 1'b0; neg_c2 = 1'b1;
    #1; chk("R6 forced positive latch, low phase", q, 4'hF);
    d = 4'h5;
    @(posedge clk); #1; chk("R6 normal negative latch, high phase", q, 4'h5);
    d = 4'h3;
    @(negedge clk); #1; chk("R6 forced positive latch, after fall", q, 4'hF);
    @(posedge clk); #1; chk("R6 high phase data", q, 4'h3);

    pos_c1 = 1'b0; pos_c2 = 1'b1;
    d = 4'hA;
    @(negedge clk); #1; chk("R7 first fall after restore", q, 4'hA);
    d = 4'h9;
    @(posedge clk); #1; chk("R7 first rise after restore", q, 4'h9);
    chk("R8 reference model after restore", q, ref_r);

    summary();
    $finish;
  end
endmodule